// File: doc/BRIEF.md
# Reloading System Tick Timer

This block is a free-running down-counter with a small register interface. Software stores a reload value, then turns the counter on. From then on the counter drops by one on every clock. After it reaches zero it takes the reload value on the next clock and keeps going. Each time it passes from one to zero it raises a sticky wrap flag. If interrupts are allowed, it also gives a one-cycle interrupt pulse that needs no acknowledge.

Three word-indexed registers sit on a simple single-cycle bus, which has a select, a write strobe, a word index, write data and combinational read data.

- Index 0 is control and status.
- Index 1 is the reload value.
- Index 2 is the live count.

Two bus accesses have side effects. A read of control clears the wrap flag. A write of any value to the live count clears the counter and the flag. Software can measure elapsed time by sampling the live count twice. With the full-range reload, the elapsed cycles are the earlier sample minus the later one, masked to the counter width.

Top module: `tick_timer`

## Requirements
- R1: The reload register keeps the low 24 bits of a write. Reading index 1 or index 2 returns a 24-bit value with bits 31:24 at zero. Index 3 reads as zero, and a write to it changes nothing.
- R2: While the enable bit is set, the count drops by one per clock. On the clock after it shows zero, it shows the reload value.
- R3: While the enable bit is clear, the count holds its value and the wrap flag is not set.
- R4: Control bit 0 is the enable and bit 1 is the interrupt enable. Bit 2 is the clock-source select, and bit 16 is the read-only wrap flag. All other bits read zero. Writing 0x5 turns counting on, keeps interrupts off and sets the source bit.
- R5: The wrap flag is set by the clock edge at which an enabled count goes from 1 to 0. It then stays set until a clearing access.
- R6: A read of index 0 returns the flag as it stands and clears it at that clock edge. If a 1-to-0 step happens on the same edge, the flag stays set.
- R7: A write of any data to index 2 clears the count and the flag at that edge. This takes precedence over a 1-to-0 step on the same edge, and no interrupt follows.
- R8: With the interrupt enable set, the interrupt output is high for exactly the one cycle after a 1-to-0 step, in which the count shows zero. It is never high with the interrupt enable clear.
- R9: After reset, all three registers read zero and the interrupt output is low.
- R10: With reload 0xFFFFFF, two samples of index 2 taken N cycles apart satisfy (earlier − later) & 0xFFFFFF = N, including across a reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the count clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_idx | input | 2 | Word index: 0 control, 1 reload, 2 count |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle, zero otherwise |
| tick_irq | output | 1 | One-cycle wrap interrupt pulse |

## Verification
The wrap flag has two competing writers on the same edge. A count step from 1 to 0 sets it, while a control read or a count write clears it. The bench polls the live count until it reads 2. It then places a control read, or a count write, in the very next cycle, when the count is 1. The following control read is checked: after the read collision the flag must still be set. After the write collision both the flag and the interrupt must be absent. A behavioural model is compared on every clock, so the edges just before and after each collision are judged as well.

// File: rtl/tick_pkg.sv
package tick_pkg;
   typedef enum logic [1:0] {
      IDX_CTRL = 2'd0,
      IDX_LOAD = 2'd1,
      IDX_CUR  = 2'd2,
      IDX_NONE = 2'd3
   } tick_idx_e;

   localparam int BIT_EN   = 0;
   localparam int BIT_IE   = 1;
   localparam int BIT_SRC  = 2;
   localparam int BIT_FLAG = 16;
endpackage

// File: rtl/tick_bus_decode.sv
module tick_bus_decode
   import tick_pkg::*;
#(
   parameter int IDX_W = 2
) (
   input  logic             sel,
   input  logic             wr,
   input  logic [IDX_W-1:0] idx,
   output logic             wr_ctrl,
   output logic             wr_load,
   output logic             wr_cur,
   output logic             rd_ctrl,
   output logic             rd_any,
   output tick_idx_e        which
);
   generate
      if (IDX_W != 2) begin : g_bad_idx
         $error("tick_bus_decode: IDX_W must be 2");
      end
   endgenerate

   always_comb begin
      which   = tick_idx_e'(idx);
      wr_ctrl = sel && wr && (which == IDX_CTRL);
      wr_load = sel && wr && (which == IDX_LOAD);
      wr_cur  = sel && wr && (which == IDX_CUR);
      rd_ctrl = sel && !wr && (which == IDX_CTRL);
      rd_any  = sel && !wr;
   end
endmodule

// File: rtl/tick_cfg_regs.sv
module tick_cfg_regs
   import tick_pkg::*;
#(
   parameter int CNT_W      = 24,
   parameter int DATA_W     = 32,
   parameter bit HAS_SRCSEL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic              wr_load,
   input  logic [DATA_W-1:0] wdata,
   output logic              en,
   output logic              ie,
   output logic              src,
   output logic [CNT_W-1:0]  reload
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en     <= 1'b0;
         ie     <= 1'b0;
         reload <= '0;
      end else begin
         if (wr_ctrl) begin
            en <= wdata[BIT_EN];
            ie <= wdata[BIT_IE];
         end
         if (wr_load) reload <= wdata[CNT_W-1:0];
      end
   end

   generate
      if (HAS_SRCSEL) begin : g_src_store
         always_ff @(posedge clk) begin
            if (!rst_n)       src <= 1'b0;
            else if (wr_ctrl) src <= wdata[BIT_SRC];
         end
      end else begin : g_src_fixed
         assign src = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/tick_down_counter.sv
module tick_down_counter #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             clr,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   assign wrap = en && !clr && (cnt == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt <= '0;
      else if (clr)           cnt <= '0;
      else if (en) begin
         if (cnt == '0)       cnt <= reload;
         else                 cnt <= cnt - ONE;
      end
   end
endmodule

// File: rtl/tick_flag_irq.sv
module tick_flag_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic wrap,
   input  logic rd_clr,
   input  logic wr_clr,
   input  logic ie,
   output logic flag,
   output logic irq
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag <= 1'b0;
         irq  <= 1'b0;
      end else begin
         if (wr_clr)      flag <= 1'b0;
         else if (wrap)   flag <= 1'b1;
         else if (rd_clr) flag <= 1'b0;
         irq <= wrap && ie;
      end
   end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
   import tick_pkg::*;
#(
   parameter int CNT_W      = 24,
   parameter int DATA_W     = 32,
   parameter int IDX_W      = 2,
   parameter bit HAS_SRCSEL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [IDX_W-1:0]  bus_idx,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              tick_irq
);
   localparam int MIN_DATA_W = BIT_FLAG + 1;

   generate
      if (DATA_W < MIN_DATA_W || CNT_W > DATA_W || CNT_W < 2) begin : g_bad_width
         $error("tick_timer: widths out of range");
      end
   endgenerate

   logic             wr_ctrl, wr_load, wr_cur, rd_ctrl, rd_any;
   tick_idx_e        which;
   logic             en_q, ie_q, src_q, flag_q, wrap;
   logic [CNT_W-1:0] reload_q, cnt_q;

   tick_bus_decode #(.IDX_W(IDX_W)) i_dec (
      .sel(bus_sel), .wr(bus_wr), .idx(bus_idx),
      .wr_ctrl(wr_ctrl), .wr_load(wr_load), .wr_cur(wr_cur),
      .rd_ctrl(rd_ctrl), .rd_any(rd_any), .which(which)
   );

   tick_cfg_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .HAS_SRCSEL(HAS_SRCSEL)) i_cfg (
      .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_load(wr_load),
      .wdata(bus_wdata), .en(en_q), .ie(ie_q), .src(src_q), .reload(reload_q)
   );

   tick_down_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk(clk), .rst_n(rst_n), .en(en_q), .clr(wr_cur),
      .reload(reload_q), .cnt(cnt_q), .wrap(wrap)
   );

   tick_flag_irq i_flag (
      .clk(clk), .rst_n(rst_n), .wrap(wrap), .rd_clr(rd_ctrl),
      .wr_clr(wr_cur), .ie(ie_q), .flag(flag_q), .irq(tick_irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (rd_any) begin
         case (which)
            IDX_CTRL: begin
               bus_rdata[BIT_EN]   = en_q;
               bus_rdata[BIT_IE]   = ie_q;
               bus_rdata[BIT_SRC]  = src_q;
               bus_rdata[BIT_FLAG] = flag_q;
            end
            IDX_LOAD: bus_rdata = DATA_W'(reload_q);
            IDX_CUR:  bus_rdata = DATA_W'(cnt_q);
            default:  bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
   parameter int CNT_W  = 24,
   parameter int DATA_W = 32,
   parameter int IDX_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [IDX_W-1:0]  bus_idx,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              tick_irq,
   input logic              en_q,
   input logic              ie_q,
   input logic              flag_q,
   input logic [CNT_W-1:0]  cnt_q
);
   logic cur_wr, ctl_rd, step1;
   assign cur_wr = bus_sel && bus_wr && (bus_idx == IDX_W'(2));
   assign ctl_rd = bus_sel && !bus_wr && (bus_idx == IDX_W'(0));
   assign step1  = en_q && (cnt_q == CNT_W'(1));

   a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_idx != IDX_W'(0)) |-> bus_rdata[DATA_W-1:CNT_W] == '0);

   a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && cnt_q != '0 && !cur_wr) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

   a_r3_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !cur_wr) |=> (cnt_q == $past(cnt_q)) && (flag_q == $past(flag_q) || !flag_q));

   a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      (step1 && !cur_wr) |=> flag_q);

   a_r6_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_rd && !step1) |=> !flag_q);

   a_r7_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
      cur_wr |=> (cnt_q == '0) && !flag_q && !tick_irq);

   a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
      tick_irq |=> !tick_irq);

   a_r8_irq_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
      (!ie_q || !step1 || cur_wr) |=> !tick_irq);
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_idx(bus_idx),
   .bus_rdata(bus_rdata), .tick_irq(tick_irq), .en_q(en_q), .ie_q(ie_q),
   .flag_q(flag_q), .cnt_q(cnt_q)
);

// File: tb/test_tick_timer.sv
module test_tick_timer;
   localparam int CLK_PERIOD = 10;
   localparam int MASK = 32'h00FF_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_idx = 2'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        tick_irq;

   int n_chk = 0;
   int n_bad = 0;

   int m_cnt, m_load;
   bit m_en, m_ie, m_src, m_flag, m_irq;

   tick_timer i_tick_timer (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tick_irq(tick_irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural reference, updated at each rising edge
   always @(posedge clk) begin
      bit wcur, wrapped, rctl;
      if (!rst_n) begin
         m_cnt = 0; m_load = 0; m_en = 0; m_ie = 0; m_src = 0; m_flag = 0; m_irq = 0;
      end else begin
         wcur    = bus_sel && bus_wr && bus_idx == 2'd2;
         rctl    = bus_sel && !bus_wr && bus_idx == 2'd0;
         wrapped = m_en && m_cnt == 1 && !wcur;
         m_irq   = wrapped && m_ie;
         if (wcur) m_flag = 0;
         else if (wrapped) m_flag = 1;
         else if (rctl) m_flag = 0;
         if (wcur) m_cnt = 0;
         else if (m_en) m_cnt = (m_cnt == 0) ? m_load : m_cnt - 1;
         if (bus_sel && bus_wr && bus_idx == 2'd1) m_load = int'(bus_wdata) & MASK;
         if (bus_sel && bus_wr && bus_idx == 2'd0) begin
            m_en = bus_wdata[0]; m_ie = bus_wdata[1]; m_src = bus_wdata[2];
         end
      end
   end

   function automatic int exp_rd();
      if (!bus_sel || bus_wr) return 0;
      case (bus_idx)
         2'd0: return int'(m_en) | (int'(m_ie) << 1) | (int'(m_src) << 2) | (int'(m_flag) << 16);
         2'd1: return m_load;
         2'd2: return m_cnt;
         default: return 0;
      endcase
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input bit s, input bit w, input logic [1:0] a,
                      input logic [31:0] d, output logic [31:0] rd);
      string tag;
      @(negedge clk);
      bus_sel = s; bus_wr = w; bus_idx = a; bus_wdata = d;
      #1;
      rd = bus_rdata;
      case (a)
         2'd0: tag = "R4 model";
         2'd2: tag = "R2 model";
         default: tag = "R1 model";
      endcase
      check(tag, int'(bus_rdata), exp_rd());
      check("R8 model", int'(tick_irq), int'(m_irq));
   endtask

   task automatic rd_reg(input logic [1:0] a, output logic [31:0] rd);
      cyc(1'b1, 1'b0, a, 32'h0, rd);
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
      logic [31:0] unused;
      cyc(1'b1, 1'b1, a, d, unused);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] v, prev, early, late;
      bit hit;
      repeat (3) @(negedge clk);
      #1;
      check("R9 irq in reset", int'(tick_irq), 0);
      @(negedge clk); rst_n = 1'b1;

      rd_reg(2'd0, v); check("R9 ctrl after reset", int'(v), 0);
      rd_reg(2'd1, v); check("R9 reload after reset", int'(v), 0);
      rd_reg(2'd2, v); check("R9 count after reset", int'(v), 0);
      check("R9 irq after reset", int'(tick_irq), 0);

      wr_reg(2'd1, 32'hABCD_EF12);
      rd_reg(2'd1, v); check("R1 reload keeps 24 bits", int'(v), 32'h00CD_EF12);
      wr_reg(2'd3, 32'hFFFF_FFFF);
      rd_reg(2'd3, v); check("R1 index 3 reads zero", int'(v), 0);
      rd_reg(2'd1, v); check("R1 index 3 write ignored", int'(v), 32'h00CD_EF12);

      wr_reg(2'd0, 32'hFFFF_FFFF);
      rd_reg(2'd0, v); check("R4 only control bits stored", int'(v), 32'h7);
      wr_reg(2'd0, 32'h5);
      rd_reg(2'd0, v); check("R4 write 0x5", int'(v), 32'h5);

      // R2: sequence with reload 3
      wr_reg(2'd0, 32'h0);
      wr_reg(2'd1, 32'd3);
      wr_reg(2'd2, 32'h1234);
      rd_reg(2'd2, v); check("R7 count write clears", int'(v), 0);
      wr_reg(2'd0, 32'h7);
      rd_reg(2'd2, prev);
      for (int i = 0; i < 12; i++) begin
         rd_reg(2'd2, v);
         check("R2 step", int'(v), (prev == 0) ? 3 : int'(prev) - 1);
         if (v == 0) check("R8 irq with count zero", int'(tick_irq), 1);
         else check("R8 irq quiet", int'(tick_irq), 0);
         prev = v;
      end
      rd_reg(2'd0, v); check("R5 flag set after wrap", int'(v[16]), 1);
      rd_reg(2'd0, v); check("R6 flag cleared by read", int'(v[16]), 0);

      // R6 collision: control read on the 1-to-0 edge
      hit = 0;
      for (int i = 0; i < 10; i++) begin
         rd_reg(2'd2, v);
         if (v == 2) begin hit = 1; break; end
      end
      check("R6 reached count 2", int'(hit), 1);
      rd_reg(2'd0, v);
      rd_reg(2'd0, v); check("R6 wrap beats read clear", int'(v[16]), 1);
      rd_reg(2'd0, v); check("R6 flag then cleared", int'(v[16]), 0);

      // R7 collision: count write on the 1-to-0 edge
      hit = 0;
      for (int i = 0; i < 10; i++) begin
         rd_reg(2'd2, v);
         if (v == 2) begin hit = 1; break; end
      end
      check("R7 reached count 2", int'(hit), 1);
      wr_reg(2'd2, 32'h0);
      rd_reg(2'd2, v); check("R7 count zero after write", int'(v), 0);
      check("R7 no irq after write", int'(tick_irq), 0);
      rd_reg(2'd0, v); check("R7 no flag after write", int'(v[16]), 0);

      // R8: interrupt enable off, no pulse
      wr_reg(2'd0, 32'h5);
      for (int i = 0; i < 10; i++) begin
         rd_reg(2'd2, v);
         check("R8 no irq when disabled", int'(tick_irq), 0);
      end

      // R3: disabled counter holds
      wr_reg(2'd0, 32'h2);
      rd_reg(2'd2, prev);
      rd_reg(2'd0, v);
      for (int i = 0; i < 6; i++) begin
         rd_reg(2'd2, v); check("R3 count holds", int'(v), int'(prev));
      end
      wr_reg(2'd1, 32'd1);
      wr_reg(2'd2, 32'h0);
      for (int i = 0; i < 4; i++) rd_reg(2'd2, v);
      rd_reg(2'd0, v); check("R3 no flag while off", int'(v[16]), 0);

      // R10: elapsed time across reload with full range
      wr_reg(2'd1, 32'h00FF_FFFF);
      wr_reg(2'd0, 32'h1);
      wr_reg(2'd2, 32'h0);
      rd_reg(2'd2, early);
      check("R10 earlier sample", int'(early), 0);
      for (int i = 0; i < 5; i++) rd_reg(2'd1, v);
      rd_reg(2'd2, late);
      check("R10 elapsed across wrap", (int'(early) - int'(late)) & MASK, 6);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule